// File: doc/BRIEF.md
# Line Write Burst Bus Master

This block is the master side of a synchronous external memory bus for cache-line writes. A line is four 32-bit words (16 bytes) that the internal side hands over in one request, with a line address, a termination mode and a wait-state count. The block turns that request into one burst write cycle. It pulses a transfer-start strobe, holds transfer-in-progress, chip select and the byte strobes, marks the cycle as a write of line size, and drives the four words in order on the data bus.

The burst ends each beat in one of two ways. With internal termination the block makes its own acknowledge: the first beat is stretched by the programmed wait-state count and every later beat takes one clock. With no wait states this gives the 2-1-1-1 pattern. With external termination the slave's active-low acknowledge input decides, and a beat ends only on an edge where it is sampled low. The mode also sets the address lines. Under external termination the longword index bits follow the beat. Under internal termination the address stays at the line start.

The internal side sees a ready/valid handshake and a one-clock completion pulse. After the final beat the bus always has one idle clock before the next transfer-start.

Top module: `lwb_master`

## Requirements
- R1: While the synchronous active-low reset is low at a clock edge, the block returns to idle. After that edge bus_ts_n, bus_tip_n and bus_cs_n are 1, bus_be_n is all ones, bus_wdata_oe is 0, req_ready is 1 and req_done is 0. A burst that is in progress is abandoned.
- R2: bus_ts_n is low for exactly one clock at the start of each burst. In that clock bus_rw is 0 (write) and bus_tsiz is 2'b11 (line). bus_tsiz stays 2'b11 through the burst. When idle, bus_tsiz is 2'b00 (longword) and bus_rw is 1.
- R3: bus_wdata_oe rises in the clock after the transfer-start clock and stays high only while beats are in progress.
- R4: With internal termination and zero wait states, transfer-in-progress lasts five clocks: two clocks for the first beat (counting the start clock) and one clock for each later beat.
- R5: With internal termination and a wait-state count N (0 to 15), only the first beat is stretched, by N clocks. Transfer-in-progress lasts N+5 clocks.
- R6: With external termination, a beat ends only on a clock edge where bus_ta_n is sampled low. While bus_ta_n is high, the address and data stay unchanged. bus_ta_n has no effect during the start clock, when idle, or under internal termination.
- R7: With external termination, address bits [3:2] equal the beat index 0, 1, 2, 3 in turn. Bits [31:4] are the line base taken from req_addr, and bits [1:0] are 0.
- R8: With internal termination, bus_addr stays at the line base (req_addr with bits [3:0] cleared) for the whole burst.
- R9: bus_cs_n, bus_tip_n and every bit of bus_be_n stay low without a break from the start clock through the final beat.
- R10: req_ready is high only when idle, and a request is taken only then. After the final acknowledge there is exactly one idle bus clock before a pending request produces its transfer-start.
- R11: Beat k drives req_wdata[32k+31:32k], captured when the request is accepted, so word 0 goes out first.
- R12: req_done is high for exactly one clock: the idle clock that follows the final acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Line write request |
| req_ready | output | 1 | Block idle, request accepted this clock if valid |
| req_addr | input | 32 | Line address, bits [3:0] ignored |
| req_wdata | input | 128 | Four line words, word 0 in bits [31:0] |
| req_ext_term | input | 1 | 1: slave acknowledges, 0: internal termination |
| req_wait | input | 4 | Wait states before the first beat (internal mode) |
| req_done | output | 1 | One-clock pulse after the final acknowledge |
| bus_ts_n | output | 1 | Transfer-start strobe, active low |
| bus_tip_n | output | 1 | Transfer in progress, active low |
| bus_rw | output | 1 | 1 read / idle, 0 write |
| bus_tsiz | output | 2 | Transfer size, 11 line, 00 longword |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_be_n | output | 4 | Byte strobes, active low |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Write data |
| bus_wdata_oe | output | 1 | Write data driven |
| bus_ta_n | input | 1 | Transfer acknowledge from slave, active low |

## Verification
The hardest case is an externally terminated burst in which the slave stalls by a different amount on each beat. The address and data must hold across the stall and then step exactly on the acknowledged edge. The stimulus drives bus_ta_n from a per-beat wait plan, so some beats stall for several clocks and others for none. Other runs pull bus_ta_n low where it must be ignored: in the start clock, during internal-mode bursts, and just before a reset that lands mid-burst. Bursts are also issued back to back, so the single idle clock falls between two real transfers.

// File: rtl/lwb_pkg.sv
package lwb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_BEAT  = 2'd2
    } lwb_state_e;

    localparam logic [1:0] TSIZ_LONG = 2'b00;
    localparam logic [1:0] TSIZ_LINE = 2'b11;

endpackage

// File: rtl/lwb_wait_ctr.sv
module lwb_wait_ctr #(
    parameter int WS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [WS_W-1:0] load_val,
    input  logic            count_en,
    output logic            zero
);

    logic [WS_W-1:0] cnt_d, cnt_q;

    assign zero = (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (count_en && !zero) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/lwb_line_buf.sv
module lwb_line_buf #(
    parameter int DATA_W = 32,
    parameter int BEATS  = 4,
    localparam int SEL_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [BEATS*DATA_W-1:0] line_in,
    input  logic [SEL_W-1:0]        sel,
    output logic [DATA_W-1:0]       word_out
);

    logic [DATA_W-1:0] words_d [BEATS];
    logic [DATA_W-1:0] words_q [BEATS];

    for (genvar g = 0; g < BEATS; g++) begin : g_word
        always_comb begin
            words_d[g] = words_q[g];
            if (load) begin
                words_d[g] = line_in[g*DATA_W +: DATA_W];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words_q[g] <= '0;
            end else begin
                words_q[g] <= words_d[g];
            end
        end
    end

    assign word_out = words_q[sel];

endmodule

// File: rtl/lwb_addr_gen.sv
module lwb_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int BEATS  = 4,
    parameter int LANES  = 4,
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int LANE_W = $clog2(LANES),
    localparam int OFF_W  = BEAT_W + LANE_W
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [BEAT_W-1:0] beat,
    input  logic              ext,
    input  logic              active,
    output logic [ADDR_W-1:0] addr_out
);

    logic [OFF_W-1:0] offset;

    if (LANE_W > 0) begin : g_lanes
        assign offset = ext ? {beat, {LANE_W{1'b0}}} : '0;
    end else begin : g_nolanes
        assign offset = ext ? beat : '0;
    end

    always_comb begin
        addr_out = '0;
        if (active) begin
            addr_out = base | {{(ADDR_W-OFF_W){1'b0}}, offset};
        end
    end

endmodule

// File: rtl/lwb_master.sv
module lwb_master
    import lwb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BEATS  = 4,
    parameter int WS_W   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [BEATS*DATA_W-1:0] req_wdata,
    input  logic                    req_ext_term,
    input  logic [WS_W-1:0]         req_wait,
    output logic                    req_done,
    output logic                    bus_ts_n,
    output logic                    bus_tip_n,
    output logic                    bus_rw,
    output logic [1:0]              bus_tsiz,
    output logic                    bus_cs_n,
    output logic [DATA_W/8-1:0]     bus_be_n,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [DATA_W-1:0]       bus_wdata,
    output logic                    bus_wdata_oe,
    input  logic                    bus_ta_n
);

    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int LINE_W = LANE_W + $clog2(BEATS);
    localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'((64'd1 << LINE_W) - 1);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    typedef struct packed {
        lwb_state_e        state;
        logic [BEAT_W-1:0] beat;
        logic              ext;
        logic [ADDR_W-1:0] base;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              load;
    logic              ws_zero;
    logic              ws_count;
    logic              beat_ack;
    logic              in_start;
    logic              in_beat;
    logic              active;
    logic              mode_ext;
    logic [DATA_W-1:0] cur_word;
    logic [ADDR_W-1:0] cur_addr;

    assign in_start = (ctl_q.state == ST_START);
    assign in_beat  = (ctl_q.state == ST_BEAT);
    assign active   = in_start || in_beat;
    assign mode_ext = ctl_q.ext;
    assign ws_count = in_beat && !ctl_q.ext && (ctl_q.beat == '0);

    // a beat closes on the slave's acknowledge, or on the internal wait budget
    always_comb begin
        beat_ack = 1'b0;
        if (in_beat) begin
            if (ctl_q.ext) begin
                beat_ack = !bus_ta_n;
            end else begin
                beat_ack = (ctl_q.beat != '0) || ws_zero;
            end
        end
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        load       = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    load        = 1'b1;
                    ctl_d.state = ST_START;
                    ctl_d.beat  = '0;
                    ctl_d.ext   = req_ext_term;
                    ctl_d.base  = req_addr & ~LINE_MASK;
                end
            end
            ST_START: begin
                ctl_d.state = ST_BEAT;
            end
            ST_BEAT: begin
                if (beat_ack) begin
                    if (ctl_q.beat == LAST_BEAT) begin
                        ctl_d.state = ST_IDLE;
                        ctl_d.beat  = '0;
                        ctl_d.done  = 1'b1;
                    end else begin
                        ctl_d.beat = ctl_q.beat + 1'b1;
                    end
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, beat: '0, ext: 1'b0, base: '0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    lwb_wait_ctr #(
        .WS_W (WS_W)
    ) wait_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (req_wait),
        .count_en (ws_count),
        .zero     (ws_zero)
    );

    lwb_line_buf #(
        .DATA_W (DATA_W),
        .BEATS  (BEATS)
    ) buf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .line_in  (req_wdata),
        .sel      (ctl_q.beat),
        .word_out (cur_word)
    );

    lwb_addr_gen #(
        .ADDR_W (ADDR_W),
        .BEATS  (BEATS),
        .LANES  (LANES)
    ) addr_i (
        .base     (ctl_q.base),
        .beat     (ctl_q.beat),
        .ext      (ctl_q.ext),
        .active   (active),
        .addr_out (cur_addr)
    );

    assign req_ready    = (ctl_q.state == ST_IDLE);
    assign req_done     = ctl_q.done;
    assign bus_ts_n     = !in_start;
    assign bus_tip_n    = !active;
    assign bus_cs_n     = !active;
    assign bus_rw       = !active;
    assign bus_tsiz     = active ? TSIZ_LINE : TSIZ_LONG;
    assign bus_be_n     = active ? '0 : '1;
    assign bus_addr     = cur_addr;
    assign bus_wdata    = in_beat ? cur_word : '0;
    assign bus_wdata_oe = in_beat;

endmodule

// File: rtl/lwb_master_chk.sv
module lwb_master_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_ready,
    input logic                req_done,
    input logic                bus_ts_n,
    input logic                bus_tip_n,
    input logic                bus_rw,
    input logic [1:0]          bus_tsiz,
    input logic                bus_cs_n,
    input logic [DATA_W/8-1:0] bus_be_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic                bus_wdata_oe,
    input logic                bus_ta_n,
    input logic                mode_ext
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (bus_ts_n && bus_tip_n && bus_cs_n && !bus_wdata_oe && req_ready));

    assert_ts_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ts_n |=> bus_ts_n);

    assert_ts_write_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ts_n |-> (!bus_rw && bus_tsiz == 2'b11));

    assert_data_after_ts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ts_n |=> bus_wdata_oe);

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wdata_oe && mode_ext && bus_ta_n) |=>
            (bus_wdata_oe && $stable(bus_wdata) && $stable(bus_addr)));

    assert_cs_with_tip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_tip_n |-> (!bus_cs_n && bus_be_n == '0));

    assert_beat_in_tip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wdata_oe |-> !bus_tip_n);

    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_tip_n && bus_cs_n));

    assert_idle_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_tip_n) |-> bus_ts_n);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);

endmodule

bind lwb_master lwb_master_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .req_done     (req_done),
    .bus_ts_n     (bus_ts_n),
    .bus_tip_n    (bus_tip_n),
    .bus_rw       (bus_rw),
    .bus_tsiz     (bus_tsiz),
    .bus_cs_n     (bus_cs_n),
    .bus_be_n     (bus_be_n),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_wdata_oe (bus_wdata_oe),
    .bus_ta_n     (bus_ta_n),
    .mode_ext     (mode_ext)
);

// File: tb/lwb_master_tb_top.sv
`timescale 1ns/1ps
module lwb_master_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic [127:0] req_wdata = '0;
    logic         req_ext_term = 1'b0;
    logic [3:0]   req_wait = '0;
    logic         req_done;
    logic         bus_ts_n, bus_tip_n, bus_rw, bus_cs_n, bus_wdata_oe;
    logic [1:0]   bus_tsiz;
    logic [3:0]   bus_be_n;
    logic [31:0]  bus_addr, bus_wdata;
    logic         bus_ta_n = 1'b1;

    always #4 clk = ~clk;

    lwb_master dut_i (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .req_ext_term (req_ext_term), .req_wait (req_wait),
        .req_done (req_done),
        .bus_ts_n (bus_ts_n), .bus_tip_n (bus_tip_n), .bus_rw (bus_rw),
        .bus_tsiz (bus_tsiz), .bus_cs_n (bus_cs_n), .bus_be_n (bus_be_n),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_wdata_oe (bus_wdata_oe), .bus_ta_n (bus_ta_n)
    );

    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // monitor: every newly presented beat is popped from the scoreboard (R7, R8, R11)
    logic        prev_oe = 1'b0;
    logic [31:0] prev_a = '0, prev_d = '0;
    always @(negedge clk) begin
        if (bus_wdata_oe === 1'b1 &&
            !(prev_oe && bus_wdata == prev_d && bus_addr == prev_a)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11 unexpected beat", bus_wdata, 32'h0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                chk(bus_addr == it.a, it.tag, bus_addr, it.a);
                chk(bus_wdata == it.d, "R11 beat data order", bus_wdata, it.d);
            end
        end
        prev_oe = (bus_wdata_oe === 1'b1);
        prev_a  = bus_addr;
        prev_d  = bus_wdata;
    end

    // driver: called at a negedge while idle; returns at the negedge of the idle clock
    task automatic run_burst(input logic [31:0] a, input logic [127:0] d, input bit ext,
                             input int ws, input int w0, input int w1, input int w2,
                             input int w3, input bit ta_in_start);
        int w[4];
        int beat = 0;
        int wc = 0;
        int tip_cycles = 1;
        int exp_cycles;
        logic [31:0] base;
        w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3;
        base = a & 32'hFFFF_FFF0;
        for (int k = 0; k < 4; k++) begin
            item_t it;
            it.a   = ext ? (base | (32'(k) << 2)) : base;
            it.d   = d[32*k +: 32];
            it.tag = ext ? "R7 address step" : "R8 address held";
            exp_q.push_back(it);
        end
        exp_cycles = ext ? (1 + w0 + w1 + w2 + w3 + 4) : (ws + 5);
        chk(req_ready == 1'b1 && bus_tip_n == 1'b1, "R10 ready when idle", {31'b0, req_ready}, 32'h1);
        req_valid    = 1'b1;
        req_addr     = a;
        req_wdata    = d;
        req_ext_term = ext;
        req_wait     = 4'(ws);
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = ~d;
        req_addr  = ~a;
        chk(bus_ts_n == 1'b0, "R10 start after one idle clock", {31'b0, bus_ts_n}, 32'h0);
        chk(bus_rw == 1'b0 && bus_tsiz == 2'b11, "R2 write line start", {29'b0, bus_rw, bus_tsiz}, 32'h3);
        chk(bus_wdata_oe == 1'b0, "R3 no data in start clock", {31'b0, bus_wdata_oe}, 32'h0);
        chk(bus_cs_n == 1'b0 && bus_be_n == 4'h0, "R9 select in start clock", {27'b0, bus_cs_n, bus_be_n}, 32'h0);
        bus_ta_n = ta_in_start ? 1'b0 : 1'b1;
        forever begin
            @(negedge clk);
            if (bus_tip_n == 1'b1 || tip_cycles > 60) break;
            tip_cycles++;
            chk(bus_ts_n == 1'b1, "R2 start strobe one clock", {31'b0, bus_ts_n}, 32'h1);
            chk(bus_wdata_oe == 1'b1, "R3 data driven during beats", {31'b0, bus_wdata_oe}, 32'h1);
            chk(bus_cs_n == 1'b0 && bus_be_n == 4'h0, "R9 continuous select", {27'b0, bus_cs_n, bus_be_n}, 32'h0);
            chk(req_ready == 1'b0, "R10 not ready in burst", {31'b0, req_ready}, 32'h0);
            chk(bus_tsiz == 2'b11, "R2 line size during burst", {30'b0, bus_tsiz}, 32'h3);
            if (ext) begin
                if (wc < w[beat]) begin
                    bus_ta_n = 1'b1;
                    wc++;
                end else begin
                    bus_ta_n = 1'b0;
                    beat++;
                    wc = 0;
                end
            end else begin
                bus_ta_n = 1'b1;
            end
        end
        bus_ta_n = 1'b1;
        chk(tip_cycles == exp_cycles,
            ext ? "R6 beat timing from acknowledge" : (ws == 0 ? "R4 2-1-1-1 timing" : "R5 first beat wait states"),
            32'(tip_cycles), 32'(exp_cycles));
        chk(req_done == 1'b1, "R12 done in idle clock", {31'b0, req_done}, 32'h1);
        chk(bus_tsiz == 2'b00 && bus_rw == 1'b1, "R2 idle size and direction", {29'b0, bus_rw, bus_tsiz}, 32'h4);
        chk(bus_wdata_oe == 1'b0, "R3 data released", {31'b0, bus_wdata_oe}, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        wrap_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(bus_ts_n && bus_tip_n && bus_cs_n && bus_be_n == 4'hF && !bus_wdata_oe,
            "R1 reset strobes", {27'b0, bus_ts_n, bus_tip_n, bus_cs_n, bus_wdata_oe, 1'b0}, 32'h1C);
        chk(req_ready == 1'b1 && req_done == 1'b0, "R1 reset handshake", {30'b0, req_ready, req_done}, 32'h2);
        // stray acknowledge while idle must do nothing (R6)
        bus_ta_n = 1'b0;
        @(negedge clk);
        bus_ta_n = 1'b1;
        chk(bus_tip_n == 1'b1 && exp_q.size() == 0, "R6 idle acknowledge ignored", {31'b0, bus_tip_n}, 32'h1);

        // internal, zero wait, low address bits ignored
        run_burst(32'h1000_0004, {32'hD3D3_0003, 32'hD2D2_0002, 32'hD1D1_0001, 32'hD0D0_0000},
                  1'b0, 0, 0, 0, 0, 0, 1'b0);
        // back to back, internal with wait states
        run_burst(32'h2000_0010, {32'hA3, 32'hA2, 32'hA1, 32'hA0}, 1'b0, 5, 0, 0, 0, 0, 1'b0);
        @(negedge clk);
        chk(req_done == 1'b0, "R12 done lasts one clock", {31'b0, req_done}, 32'h0);
        // external, no stalls, acknowledge low in start clock ignored
        run_burst(32'h3000_002C, {32'hB3, 32'hB2, 32'hB1, 32'hB0}, 1'b1, 0, 0, 0, 0, 0, 1'b1);
        // external, uneven stalls
        run_burst(32'h4000_0040, {32'hC3, 32'hC2, 32'hC1, 32'hC0}, 1'b1, 0, 2, 0, 3, 1, 1'b0);
        // internal, maximum wait
        run_burst(32'h5000_0050, {32'hE3, 32'hE2, 32'hE1, 32'hE0}, 1'b0, 15, 0, 0, 0, 0, 1'b0);

        // reset in the middle of a stalled external burst (R1)
        @(negedge clk);
        begin
            item_t it;
            it.a = 32'h6000_0060; it.d = 32'hF0; it.tag = "R7 address step";
            exp_q.push_back(it);
        end
        req_valid = 1'b1; req_addr = 32'h6000_0060; req_ext_term = 1'b1;
        req_wdata = {32'hF3, 32'hF2, 32'hF1, 32'hF0};
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(bus_wdata_oe == 1'b1, "R6 stalled beat held", {31'b0, bus_wdata_oe}, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(bus_tip_n && bus_cs_n && bus_ts_n && !bus_wdata_oe && req_ready,
            "R1 reset aborts burst", {27'b0, bus_tip_n, bus_cs_n, bus_ts_n, bus_wdata_oe, req_ready}, 32'h1D);
        rst_n = 1'b1;
        @(negedge clk);
        chk(exp_q.size() == 0, "R11 scoreboard after abort", 32'(exp_q.size()), 32'h0);

        run_burst(32'h7000_0074, {32'h1234_0003, 32'h1234_0002, 32'h1234_0001, 32'h1234_0000},
                  1'b0, 2, 0, 0, 0, 0, 1'b0);
        @(negedge clk);
        chk(exp_q.size() == 0, "R11 all beats seen", 32'(exp_q.size()), 32'h0);
        wrap_up();
    end

endmodule